// File: doc/BRIEF.md
# Subgroup Masked Reduction Unit

The unit folds one integer operand from every lane of a 64-lane subgroup into a single value. A per-lane active mask selects which lanes take part; a lane whose mask bit is clear joins the reduction as the identity of the selected operation. Because of this, a partial or even empty set of active lanes still yields a correct result. The five supported operations are wrapping add, unsigned minimum, signed minimum, unsigned maximum and signed maximum.

A caller presents the lane data, the mask and an opcode together with a one-cycle start pulse. The operands travel through a binary tree with one register per level, so 64 lanes give six levels. The result appears with a one-cycle done pulse exactly six cycles after the start. A new start may be issued on every cycle. The operand width is a parameter, and 16, 32 and 64 bits are the intended settings.

Top module: `subgroup_reducer`

## Requirements
- R1: With opcode 0 (add), the result is the sum of all active lanes' operands modulo 2^WIDTH, and it wraps on overflow without saturating.
- R2: With opcode 1 (unsigned minimum), the result is the smallest active operand when operands are compared as unsigned numbers.
- R3: With opcode 2 (signed minimum), the result is the smallest active operand when operands are compared as two's complement numbers.
- R4: With opcode 3 (unsigned maximum), the result is the largest active operand when operands are compared as unsigned numbers.
- R5: With opcode 4 (signed maximum), the result is the largest active operand when operands are compared as two's complement numbers.
- R6: The operand of a lane whose bit in laneMask (bit n for lane n, which holds laneData bits n*WIDTH upward) is clear has no effect on the result.
- R7: An all-zero mask returns the identity of the opcode: 0 for add and unsigned maximum, all ones for unsigned minimum, the largest positive value for signed minimum, and the most negative value for signed maximum.
- R8: doneOut is high for one cycle exactly 6 cycles after each cycle in which startIn is high, and it is never high otherwise.
- R9: Starts issued on consecutive cycles each produce their own result, in issue order, on consecutive cycles.
- R10: resultOut changes only in a cycle where doneOut is high, and it holds its value between done pulses.
- R11: While reset is held, doneOut is low and resultOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Begin a reduction of the values presented this cycle |
| opIn | input | 3 | Operation code (0 add, 1 unsigned min, 2 signed min, 3 unsigned max, 4 signed max) |
| laneMask | input | LANES | Active-lane mask, one bit per lane |
| laneData | input | LANES*WIDTH | Lane operands, lane n in bits n*WIDTH upward |
| resultOut | output | WIDTH | Reduced value |
| doneOut | output | 1 | One-cycle pulse when resultOut carries a new result |

## Verification
On every cycle the assertions check that the final tree level of a minimum or maximum keeps one of its two inputs and orders correctly against both. They also check that no done pulse appears without an outstanding start, that no more reductions are in flight than the tree has levels, and that the result changes only on a done pulse. Only the bench scenarios can show that whole reductions are correct. These include the wrapping sum, the handling of inactive lanes that hold extreme values, the identities returned for an empty mask, and the exact six-cycle latency with back-to-back ordering. A behavioural model predicts each of these values independently.

// File: rtl/reduce_pkg.sv
package reduce_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_UMIN = 3'd1,
    OP_SMIN = 3'd2,
    OP_UMAX = 3'd3,
    OP_SMAX = 3'd4
  } redOp_e;

  // per-level strobe handed from control to datapath
  typedef struct packed {
    logic   valid;
    redOp_e op;
  } stageCtl_t;

endpackage

// File: rtl/reduce_ctrl.sv
module reduce_ctrl
  import reduce_pkg::*;
#(
  parameter int LEVELS = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startIn,
  input  redOp_e                 opIn,
  output stageCtl_t [LEVELS:0]   ctlVec
);

  localparam int CNT_W = $clog2(LEVELS + 2) + 1;

  stageCtl_t                 ctlNow;
  stageCtl_t [LEVELS-1:0]    ctlPipe;

  assign ctlNow = '{valid: startIn, op: opIn};
  assign ctlVec = {ctlPipe, ctlNow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlPipe <= '0;
    end else begin
      ctlPipe <= {ctlPipe[LEVELS-2:0], ctlNow};
    end
  end

  // outstanding-start tracker for the checks below
  logic [CNT_W-1:0] inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight <= '0;
    end else begin
      inFlight <= inFlight + CNT_W'(startIn) - CNT_W'(ctlVec[LEVELS].valid);
    end
  end

  // R8
  done_has_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlVec[LEVELS].valid |-> (inFlight != '0));

  // R9
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= CNT_W'(LEVELS));

endmodule

// File: rtl/reduce_dp.sv
module reduce_dp
  import reduce_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int WIDTH  = 32,
  parameter int LEVELS = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [LANES-1:0]         laneMask,
  input  logic [LANES*WIDTH-1:0]   laneData,
  input  stageCtl_t [LEVELS:0]     ctlVec,
  output logic [WIDTH-1:0]         resultOut
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] POS_MAX  = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_MAX  = {1'b1, {(WIDTH-1){1'b0}}};

  function automatic logic [WIDTH-1:0] identityOf(redOp_e op);
    case (op)
      OP_UMIN: return ALL_ONES;
      OP_SMIN: return POS_MAX;
      OP_SMAX: return NEG_MAX;
      default: return '0;
    endcase
  endfunction

  function automatic logic [WIDTH-1:0] combine(redOp_e op,
                                               logic [WIDTH-1:0] a,
                                               logic [WIDTH-1:0] b);
    case (op)
      OP_UMIN: return (a < b) ? a : b;
      OP_SMIN: return ($signed(a) < $signed(b)) ? a : b;
      OP_UMAX: return (a > b) ? a : b;
      OP_SMAX: return ($signed(a) > $signed(b)) ? a : b;
      default: return a + b;
    endcase
  endfunction

  logic [WIDTH-1:0] leafVal [LANES];
  logic [WIDTH-1:0] nodeReg [LANES-1];

  // leaves: inactive lanes replaced by the operation identity
  for (genvar lane = 0; lane < LANES; lane++) begin : g_leaf
    assign leafVal[lane] = laneMask[lane] ? laneData[lane*WIDTH +: WIDTH]
                                          : identityOf(ctlVec[0].op);
  end

  // registered tree, heap-indexed; level 0 is next to the leaves
  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_lvl
    localparam int DEPTH = LEVELS - 1 - lvl;
    localparam int NODES = 1 << DEPTH;
    localparam int BASE  = NODES - 1;
    for (genvar j = 0; j < NODES; j++) begin : g_node
      logic [WIDTH-1:0] lhs;
      logic [WIDTH-1:0] rhs;
      if (lvl == 0) begin : g_fromLeaf
        assign lhs = leafVal[2*j];
        assign rhs = leafVal[2*j+1];
      end else begin : g_fromNode
        assign lhs = nodeReg[2*(BASE+j)+1];
        assign rhs = nodeReg[2*(BASE+j)+2];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          nodeReg[BASE+j] <= '0;
        end else if (ctlVec[lvl].valid) begin
          nodeReg[BASE+j] <= combine(ctlVec[lvl].op, lhs, rhs);
        end
      end
    end
  end

  assign resultOut = nodeReg[0];

  // root-level checks against its two children (needs LEVELS >= 2)
  logic   rootLoad;
  redOp_e rootOp;
  assign rootLoad = ctlVec[LEVELS-1].valid;
  assign rootOp   = ctlVec[LEVELS-1].op;

  // R2
  umin_root_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rootLoad && rootOp == OP_UMIN) |=>
      (nodeReg[0] <= $past(nodeReg[1])) && (nodeReg[0] <= $past(nodeReg[2])) &&
      ((nodeReg[0] == $past(nodeReg[1])) || (nodeReg[0] == $past(nodeReg[2]))));

  // R3
  smin_root_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rootLoad && rootOp == OP_SMIN) |=>
      ($signed(nodeReg[0]) <= $signed($past(nodeReg[1]))) &&
      ($signed(nodeReg[0]) <= $signed($past(nodeReg[2]))) &&
      ((nodeReg[0] == $past(nodeReg[1])) || (nodeReg[0] == $past(nodeReg[2]))));

  // R4
  umax_root_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rootLoad && rootOp == OP_UMAX) |=>
      (nodeReg[0] >= $past(nodeReg[1])) && (nodeReg[0] >= $past(nodeReg[2])) &&
      ((nodeReg[0] == $past(nodeReg[1])) || (nodeReg[0] == $past(nodeReg[2]))));

  // R5
  smax_root_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rootLoad && rootOp == OP_SMAX) |=>
      ($signed(nodeReg[0]) >= $signed($past(nodeReg[1]))) &&
      ($signed(nodeReg[0]) >= $signed($past(nodeReg[2]))) &&
      ((nodeReg[0] == $past(nodeReg[1])) || (nodeReg[0] == $past(nodeReg[2]))));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultOut) |-> ctlVec[LEVELS].valid);

endmodule

// File: rtl/subgroup_reducer.sv
module subgroup_reducer
  import reduce_pkg::*;
#(
  parameter int LANES = 64,
  parameter int WIDTH = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startIn,
  input  logic [2:0]              opIn,
  input  logic [LANES-1:0]        laneMask,
  input  logic [LANES*WIDTH-1:0]  laneData,
  output logic [WIDTH-1:0]        resultOut,
  output logic                    doneOut
);

  localparam int LEVELS = $clog2(LANES);

  stageCtl_t [LEVELS:0] ctlVec;

  reduce_ctrl #(
    .LEVELS (LEVELS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .opIn    (redOp_e'(opIn)),
    .ctlVec  (ctlVec)
  );

  reduce_dp #(
    .LANES  (LANES),
    .WIDTH  (WIDTH),
    .LEVELS (LEVELS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .laneMask  (laneMask),
    .laneData  (laneData),
    .ctlVec    (ctlVec),
    .resultOut (resultOut)
  );

  assign doneOut = ctlVec[LEVELS].valid;

endmodule

// File: tb/subgroup_reducer_bench.sv
module subgroup_reducer_bench;

  localparam int LANES = 64;
  localparam int W     = 32;
  localparam int LAT   = 6;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               startIn = 1'b0;
  logic [2:0]         opIn = '0;
  logic [LANES-1:0]   laneMask = '0;
  logic [LANES*W-1:0] laneData = '0;
  logic [W-1:0]       resultOut;
  logic               doneOut;

  always #10 clk = ~clk;

  subgroup_reducer #(.LANES(LANES), .WIDTH(W)) u_subgroup_reducer (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opIn(opIn),
    .laneMask(laneMask), .laneData(laneData),
    .resultOut(resultOut), .doneOut(doneOut)
  );

  typedef struct {
    int         due;
    logic [W-1:0] val;
    string      tag;
  } expect_t;

  expect_t      pendQ[$];
  int           edgeCount = 0;
  int           checks = 0;
  int           fails = 0;
  logic [W-1:0] lastResult = '0;
  bit           finished = 1'b0;

  always @(posedge clk) edgeCount++;

  function automatic logic [W-1:0] refReduce(int op, logic [LANES-1:0] m,
                                             logic [LANES*W-1:0] d);
    logic [W-1:0] acc;
    logic [W-1:0] v;
    case (op)
      1: acc = '1;
      2: acc = {1'b0, {(W-1){1'b1}}};
      4: acc = {1'b1, {(W-1){1'b0}}};
      default: acc = '0;
    endcase
    for (int l = 0; l < LANES; l++) begin
      if (m[l]) begin
        v = d[l*W +: W];
        case (op)
          0: acc = acc + v;
          1: if (v < acc) acc = v;
          2: if ($signed(v) < $signed(acc)) acc = v;
          3: if (v > acc) acc = v;
          4: if ($signed(v) > $signed(acc)) acc = v;
          default: acc = acc;
        endcase
      end
    end
    return acc;
  endfunction

  function automatic logic [LANES*W-1:0] randData();
    logic [LANES*W-1:0] d;
    for (int l = 0; l < LANES; l++) d[l*W +: W] = $urandom;
    return d;
  endfunction

  task automatic checkVal(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (edge %0d)", tag, act, exp, edgeCount);
    end
  endtask

  task automatic observe();
    if (pendQ.size() > 0 && pendQ[0].due == edgeCount) begin
      checkVal("R8 done pulse", W'(doneOut), W'(1));
      checkVal(pendQ[0].tag, resultOut, pendQ[0].val);
      lastResult = pendQ[0].val;
      void'(pendQ.pop_front());
    end else begin
      checkVal("R8 done idle", W'(doneOut), W'(0));
      checkVal("R10 result hold", resultOut, lastResult);
    end
  endtask

  task automatic tick(bit st, int op, logic [LANES-1:0] m,
                      logic [LANES*W-1:0] d, string tag);
    expect_t e;
    @(negedge clk);
    observe();
    startIn  = st;
    opIn     = 3'(op);
    laneMask = m;
    laneData = d;
    if (st) begin
      e.due = edgeCount + LAT;
      e.val = refReduce(op, m, d);
      e.tag = tag;
      pendQ.push_back(e);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 0, '0, '0, "");
  endtask

  initial begin : watchdog
    #(20 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stimulus
    string opTag [5];
    logic [LANES-1:0]   partMask;
    logic [LANES*W-1:0] d1;
    logic [LANES*W-1:0] d2;
    opTag[0] = "R1 add";
    opTag[1] = "R2 umin";
    opTag[2] = "R3 smin";
    opTag[3] = "R4 umax";
    opTag[4] = "R5 smax";
    partMask = 64'hF0F0_1234_8000_0001;

    // R11: reset state
    repeat (3) @(negedge clk);
    checkVal("R11 done in reset", W'(doneOut), W'(0));
    checkVal("R11 result in reset", resultOut, '0);
    rstN = 1'b1;
    idle(2);

    // R1..R5: full, partial and single-lane masks
    for (int op = 0; op < 5; op++) begin
      tick(1'b1, op, '1, randData(), opTag[op]);
      tick(1'b1, op, partMask, randData(), opTag[op]);
      tick(1'b1, op, 64'h1 << 37, randData(), opTag[op]);
      idle(1);
    end
    idle(LAT + 2);

    // R1: wrap without saturation (64 x all-ones = -64)
    tick(1'b1, 0, '1, '1, "R1 wrap");
    idle(LAT + 2);

    // R7: empty mask yields identity for each opcode
    for (int op = 0; op < 5; op++) tick(1'b1, op, '0, randData(), "R7 identity");
    idle(LAT + 2);

    // R6: inactive lanes with extreme values must not matter
    for (int op = 0; op < 5; op++) begin
      d1 = randData();
      d2 = d1;
      for (int l = 0; l < LANES; l++) begin
        if (!partMask[l]) begin
          d1[l*W +: W] = (l % 2 == 0) ? {1'b1, {(W-1){1'b0}}} : '0;
          d2[l*W +: W] = (l % 2 == 0) ? {1'b0, {(W-1){1'b1}}} : '1;
        end
      end
      tick(1'b1, op, partMask, d1, "R6 masked lanes A");
      tick(1'b1, op, partMask, d2, "R6 masked lanes B");
    end
    idle(LAT + 2);

    // R9: back-to-back starts, one per cycle
    for (int k = 0; k < 14; k++) begin
      tick(1'b1, k % 5, {$urandom, $urandom}, randData(), "R9 back-to-back");
    end
    idle(LAT + 4);

    if (pendQ.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R8: actual %0d pending expected 0", pendQ.size());
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule